// File: doc/BRIEF.md
# SDR SDRAM Device Model

A synthesizable stand-in for one single-data-rate SDRAM chip with several internal banks, meant to sit on the far side of an SDRAM controller under test. It watches the chip-select / row-strobe / column-strobe / write-strobe command bus, keeps one open row per bank, stores written bytes in an internal array, and hands read data back on a registered read bus after the column latency programmed through a mode-register write.

Only single-beat accesses are modelled. Refresh timing, burst sequencing and auto-precharge are not performed. The model reports protocol violations as it runs, on sticky error outputs. The tri-state data bus is split into a read bus driven by the model, a write bus, and the controller's output-enable.

Top module: `sdram_dev_model`

## Requirements
- R1: While reset is asserted, `dq_rd` is zero, every error output is zero, every bank is closed and no column latency is selected.
- R2: A command is taken only when `cs_n` is low at a rising edge and `cke` was high at the rising edge before it. Otherwise the command has no effect.
- R3: The command code is {`ras_n`,`cas_n`,`we_n`}: 0 mode set, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 7 no-op. A taken code 6 sets `err_unknown`. Refresh and no-op change nothing.
- R4: A mode set is applied only when `ba` is 0 and `addr[10]` is 0. The latency is taken from `addr[6:4]`. The burst field `addr[2:0]` has no effect. An applied mode set with any bit of `addr & 0x388` set raises `err_mode`.
- R5: Activate opens bank `ba` at row `addr[ROW_W-1:0]`. Activating a bank that is already open raises `err_reopen`.
- R6: Precharge with `addr[10]`=1 closes all banks. With `addr[10]`=0 it closes only bank `ba`.
- R7: A write to an open bank stores byte lane i (`dq_wr[8i+7:8i]`) at column `addr[COL_W-1:0]` of the bank's open row only when `dqm[i]` is 0.
- R8: With latency 2, the data of a read taken at edge k appears on `dq_rd` after edge k+1. With latency 3 it appears after edge k+2. All byte lanes are returned, and the data holds until a later read replaces it.
- R9: While the selected latency is neither 2 nor 3, `dq_rd` holds its value.
- R10: A read or write to a closed bank raises `err_closed`. Such a write stores nothing, and such a read returns all-zero data.
- R11: A read or write with `addr[10]`=1 raises `err_autopre`. A write with `dq_oe`=0, or a read with `dq_oe`=1, raises `err_dir`. In both cases the access is still performed.
- R12: Every error output, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; gates the next command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe (command code bit 2) |
| cas_n | input | 1 | Column strobe (command code bit 1) |
| we_n | input | 1 | Write strobe (command code bit 0) |
| ba | input | $clog2(BANKS) | Bank select |
| addr | input | ADDR_W | Row, column or mode word |
| dqm | input | LANES | Per-lane write mask, 1 = masked |
| dq_wr | input | LANES*8 | Write data from the controller |
| dq_oe | input | 1 | Controller is driving the data bus |
| dq_rd | output | LANES*8 | Read data toward the controller |
| err_unknown | output | 1 | Unsupported command code seen |
| err_mode | output | 1 | Reserved mode bits set |
| err_reopen | output | 1 | Activate on an open bank |
| err_closed | output | 1 | Access to a closed bank |
| err_autopre | output | 1 | Auto-precharge requested |
| err_dir | output | 1 | Data bus direction mismatch |

## Verification
Some properties are checked on every cycle by the assertions:
- a command that is not taken leaves bank and latency state untouched;
- the error outputs never drop;
- activate opens the addressed bank, and precharge-all empties the open set;
- latency 2 forwards the captured data one edge later, and an unsupported latency freezes the read bus;
- code 6 raises its flag.

Other behaviour only the bench scenarios can show:
- byte-lane masking and row/column placement in storage, checked against a reference array;
- exact latency-3 timing;
- mode sets that are ignored;
- discarded writes to closed banks;
- that violating accesses are still performed.

// File: rtl/sdram_model_pkg.sv
package sdram_model_pkg;

  typedef enum logic [2:0] {
    OP_MODE = 3'd0,
    OP_REFR = 3'd1,
    OP_PRE  = 3'd2,
    OP_ACT  = 3'd3,
    OP_WR   = 3'd4,
    OP_RD   = 3'd5,
    OP_BAD  = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  localparam logic [10:0] MODE_RSVD = 11'h388;

  function automatic logic lat_ok(input logic [2:0] lat);
    return (lat == 3'd2) || (lat == 3'd3);
  endfunction

  function automatic logic mode_bad(input logic [10:0] word);
    return |(word & MODE_RSVD);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_model_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic cke_armed,
  output logic take,
  output op_e  op
);

  always_ff @(posedge clk) begin
    if (!rst_n) cke_armed <= 1'b0;
    else        cke_armed <= cke;
  end

  assign take = !cs_n && cke_armed;
  assign op   = op_e'({ras_n, cas_n, we_n});

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_fire,
  input  logic              pre_fire,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  row_in,
  output logic [BANKS-1:0]  open_vec,
  output logic              sel_open,
  output logic [ROW_W-1:0]  sel_row,
  output logic              reopen_evt
);

  logic [ROW_W-1:0] row_q [BANKS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        open_vec[b] <= 1'b0;
        row_q[b]    <= '0;
      end
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (pre_fire && (pre_all || ba == BANK_W'(b))) open_vec[b] <= 1'b0;
        if (act_fire && ba == BANK_W'(b)) begin
          open_vec[b] <= 1'b1;
          row_q[b]    <= row_in;
        end
      end
    end
  end

  assign sel_open   = open_vec[ba];
  assign sel_row    = row_q[ba];
  assign reopen_evt = act_fire && sel_open;

  a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> open_vec[$past(ba)]);

  a_r6_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_fire && pre_all) |=> (open_vec == '0));

endmodule

// File: rtl/sdram_lane_mem.sv
module sdram_lane_mem #(
  parameter int IDX_W = 10,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       wdata,
  input  logic             re,
  input  logic             rd_zero,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_zero ? 8'h00 : mem[idx];
  end

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_model_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      lat,
  input  logic [DQ_W-1:0] stage1,
  output logic [DQ_W-1:0] dq_rd
);

  logic [DQ_W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage2 <= '0;
      dq_rd  <= '0;
    end else begin
      stage2 <= stage1;
      if (lat_ok(lat)) dq_rd <= (lat == 3'd2) ? stage1 : stage2;
    end
  end

  a_r9_hold_bad_lat: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_ok(lat) |=> $stable(dq_rd));

  a_r8_lat2_path: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == 3'd2) |=> (dq_rd == $past(stage1)));

endmodule

// File: rtl/sdram_dev_model.sv
module sdram_dev_model
  import sdram_model_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BANKS  = 4,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [$clog2(BANKS)-1:0]   ba,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES-1:0]           dqm,
  input  logic [LANES*8-1:0]         dq_wr,
  input  logic                       dq_oe,
  output logic [LANES*8-1:0]         dq_rd,
  output logic                       err_unknown,
  output logic                       err_mode,
  output logic                       err_reopen,
  output logic                       err_closed,
  output logic                       err_autopre,
  output logic                       err_dir
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int DQ_W   = LANES * 8;
  localparam int IDX_W  = BANK_W + ROW_W + COL_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic cke_armed, take;
  op_e  op;

  sdram_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke_armed(cke_armed), .take(take), .op(op)
  );

  // Named command events
  logic mode_fire, act_fire, pre_fire, wr_fire, rd_fire, bad_fire, acc_fire;
  assign mode_fire = take && op == OP_MODE && ba == '0 && !addr[10];
  assign act_fire  = take && op == OP_ACT;
  assign pre_fire  = take && op == OP_PRE;
  assign wr_fire   = take && op == OP_WR;
  assign rd_fire   = take && op == OP_RD;
  assign bad_fire  = take && op == OP_BAD;
  assign acc_fire  = wr_fire || rd_fire;

  logic [BANKS-1:0] open_vec;
  logic             sel_open, reopen_evt;
  logic [ROW_W-1:0] sel_row;

  sdram_bank_state #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .act_fire(act_fire), .pre_fire(pre_fire),
    .pre_all(addr[10]), .ba(ba), .row_in(addr[ROW_W-1:0]),
    .open_vec(open_vec), .sel_open(sel_open), .sel_row(sel_row),
    .reopen_evt(reopen_evt)
  );

  logic [IDX_W-1:0] idx;
  assign idx = {ba, sel_row, addr[COL_W-1:0]};

  logic [DQ_W-1:0] stage1;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sdram_lane_mem #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we(wr_fire && sel_open && !dqm[i]), .wdata(dq_wr[8*i +: 8]),
      .re(rd_fire), .rd_zero(!sel_open), .idx(idx),
      .rdata(stage1[8*i +: 8])
    );
  end

  logic [2:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)         lat_q <= 3'd0;
    else if (mode_fire) lat_q <= addr[6:4];
  end

  sdram_rd_pipe #(.DQ_W(DQ_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .lat(lat_q), .stage1(stage1), .dq_rd(dq_rd)
  );

  // Sticky protocol checks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {err_unknown, err_mode, err_reopen, err_closed, err_autopre, err_dir} <= '0;
    end else begin
      if (bad_fire)                          err_unknown <= 1'b1;
      if (mode_fire && mode_bad(addr[10:0])) err_mode    <= 1'b1;
      if (reopen_evt)                        err_reopen  <= 1'b1;
      if (acc_fire && !sel_open)             err_closed  <= 1'b1;
      if (acc_fire && addr[10])              err_autopre <= 1'b1;
      if ((wr_fire && !dq_oe) || (rd_fire && dq_oe)) err_dir <= 1'b1;
    end
  end

  logic unused_hi_addr;
  assign unused_hi_addr = ^addr[ADDR_W-1:11];

  logic [5:0] err_vec;
  assign err_vec = {err_unknown, err_mode, err_reopen, err_closed, err_autopre, err_dir};

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_vec & $past(err_vec)) == $past(err_vec)));

  a_r2_no_take_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke_armed) |=> ($stable(open_vec) && $stable(lat_q) && $stable(err_vec)));

  a_r3_bad_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cke_armed && {ras_n, cas_n, we_n} == 3'd6) |=> err_unknown);

endmodule

// File: tb/sdram_dev_model_tb.sv
module sdram_dev_model_tb;
  localparam int LANES = 2, BANKS = 4, ROW_W = 4, COL_W = 4, ADDR_W = 13;
  localparam int DQ_W = LANES * 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0] dqm;
  logic [DQ_W-1:0] dq_wr, dq_rd;
  logic err_unknown, err_mode, err_reopen, err_closed, err_autopre, err_dir;

  sdram_dev_model #(.LANES(LANES), .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
                    .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .dq_wr(dq_wr), .dq_oe(dq_oe),
    .dq_rd(dq_rd), .err_unknown(err_unknown), .err_mode(err_mode),
    .err_reopen(err_reopen), .err_closed(err_closed), .err_autopre(err_autopre),
    .err_dir(err_dir)
  );

  int total = 0, fails = 0;
  int lat_b = 0;
  logic [ROW_W-1:0] brow [BANKS];
  logic [DQ_W-1:0]  ref_mem [1 << (2 + ROW_W + COL_W)];

  function automatic int ref_idx(input int b, input int r, input int c);
    return (b << (ROW_W + COL_W)) | (r << COL_W) | c;
  endfunction

  function automatic logic [DQ_W-1:0] merge(input logic [DQ_W-1:0] old,
      input logic [DQ_W-1:0] d, input logic [LANES-1:0] m);
    logic [DQ_W-1:0] r = old;
    for (int i = 0; i < LANES; i++) if (!m[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] errs();
    return {err_unknown, err_mode, err_reopen, err_closed, err_autopre, err_dir};
  endfunction

  task automatic issue(input logic [2:0] code, input logic [1:0] b,
                       input logic [ADDR_W-1:0] a, input logic [LANES-1:0] m,
                       input logic [DQ_W-1:0] d, input logic oe);
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
    dqm = m; dq_wr = d; dq_oe = oe;
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'd7; dq_oe = 1'b0;
  endtask

  task automatic wr(input int b, input int c, input logic [DQ_W-1:0] d,
                    input logic [LANES-1:0] m);
    issue(3'd4, 2'(b), ADDR_W'(c), m, d, 1'b1);
    ref_mem[ref_idx(b, brow[b], c)] = merge(ref_mem[ref_idx(b, brow[b], c)], d, m);
  endtask

  task automatic rd_expect(input int b, input int c, input logic [DQ_W-1:0] exp,
                           input string req);
    logic [DQ_W-1:0] prev = dq_rd;
    issue(3'd5, 2'(b), ADDR_W'(c), '0, '0, 1'b0);
    if (lat_b == 3) begin
      @(negedge clk);
      check(req, "lat3 data not early", 32'(dq_rd), 32'(prev));
    end
    @(negedge clk);
    check(req, "read data", 32'(dq_rd), 32'(exp));
  endtask

  task automatic set_lat(input int l);
    issue(3'd0, 2'd0, ADDR_W'(l << 4), '0, '0, 1'b0);
    lat_b = l;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cke = 0; cs_n = 1; {ras_n, cas_n, we_n} = 3'd7;
    ba = 0; addr = 0; dqm = 0; dq_wr = 0; dq_oe = 0;
    repeat (3) @(negedge clk);
    check("R1", "dq_rd at reset", 32'(dq_rd), 0);
    check("R1", "errors at reset", 32'(errs()), 0);
    cke = 1; rst_n = 1;

    // R2: command with cke low the edge before, and command with cs_n high
    @(negedge clk); cke = 0;
    @(negedge clk); cke = 1; cs_n = 0; {ras_n, cas_n, we_n} = 3'd3; ba = 0; addr = 5;
    @(negedge clk); cs_n = 1;
    @(negedge clk); cs_n = 1; {ras_n, cas_n, we_n} = 3'd3;
    @(negedge clk); {ras_n, cas_n, we_n} = 3'd7;
    for (int b = 0; b < BANKS; b++) begin
      brow[b] = ROW_W'($urandom);
      issue(3'd3, 2'(b), ADDR_W'(brow[b]), '0, '0, 1'b0);
    end
    check("R2", "gated activates ignored (no reopen)", 32'(err_reopen), 0);
    issue(3'd1, 2'd0, '0, '0, '0, 1'b0);
    check("R3", "refresh leaves errors clear", 32'(errs()), 0);

    // R4/R9: ignored mode sets keep an unsupported latency
    issue(3'd0, 2'd1, 13'h020, '0, '0, 1'b0);
    issue(3'd0, 2'd0, 13'h420, '0, '0, 1'b0);
    wr(0, 1, 16'hBEEF, 2'b00);
    issue(3'd5, 2'd0, 13'd1, '0, '0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      check("R9", "dq_rd held without valid latency", 32'(dq_rd), 0);
      @(negedge clk);
    end
    issue(3'd0, 2'd0, 13'h023, '0, '0, 1'b0);
    lat_b = 2;
    rd_expect(0, 1, 16'hBEEF, "R4");
    check("R4", "clean mode set no flag", 32'(err_mode), 0);

    // R7: lane masks
    wr(0, 1, 16'h1234, 2'b10);
    rd_expect(0, 1, 16'hBE34, "R7");
    wr(0, 1, 16'h5600, 2'b01);
    rd_expect(0, 1, 16'h5634, "R7");
    wr(0, 1, 16'hFFFF, 2'b11);
    rd_expect(0, 1, 16'h5634, "R7");

    // R8: latency 3 exact timing
    set_lat(3);
    rd_expect(0, 1, 16'h5634, "R8");

    // R7/R8: fill then random traffic
    for (int b = 0; b < BANKS; b++)
      for (int c = 0; c < (1 << COL_W); c++) wr(b, c, DQ_W'($urandom), 2'b00);
    for (int n = 0; n < 300; n++) begin
      int b = int'($urandom_range(BANKS - 1));
      int c = int'($urandom_range((1 << COL_W) - 1));
      case ($urandom_range(9))
        0: set_lat(($urandom_range(1) == 0) ? 2 : 3);
        1, 2, 3, 4: wr(b, c, DQ_W'($urandom), LANES'($urandom));
        default: rd_expect(b, c, ref_mem[ref_idx(b, brow[b], c)], "R8");
      endcase
    end
    check("R12", "no errors after legal traffic", 32'(errs()), 0);

    // R11: violations still perform the access
    wr(0, 2, 16'hA5A5, 2'b00);
    issue(3'd4, 2'd0, 13'h402, '0, 16'h0F0F, 1'b1);
    ref_mem[ref_idx(0, brow[0], 2)] = 16'h0F0F;
    check("R11", "autopre flag", 32'(err_autopre), 1);
    check("R11", "dir flag still clear", 32'(err_dir), 0);
    issue(3'd5, 2'd0, 13'd2, '0, '0, 1'b1);
    repeat (2) @(negedge clk);
    check("R11", "read with wrong direction still returns data", 32'(dq_rd), 32'h0F0F);
    check("R11", "dir flag", 32'(err_dir), 1);

    // R6/R5/R10
    issue(3'd2, 2'd1, 13'h000, '0, '0, 1'b0);
    issue(3'd3, 2'd1, ADDR_W'(brow[1]), '0, '0, 1'b0);
    check("R6", "single precharge closed bank 1", 32'(err_reopen), 0);
    issue(3'd3, 2'd0, ADDR_W'(brow[0]), '0, '0, 1'b0);
    check("R5", "reopen flag on open bank 0", 32'(err_reopen), 1);
    check("R10", "closed flag still clear", 32'(err_closed), 0);
    issue(3'd2, 2'd3, 13'h400, '0, '0, 1'b0);
    issue(3'd4, 2'd2, 13'd5, '0, 16'hDEAD, 1'b1);
    check("R10", "closed-bank write flag", 32'(err_closed), 1);
    rd_expect(2, 5, 16'h0000, "R10");
    issue(3'd3, 2'd2, ADDR_W'(brow[2]), '0, '0, 1'b0);
    rd_expect(2, 5, ref_mem[ref_idx(2, brow[2], 5)], "R10");

    // R3/R4: bad code and reserved mode bits
    check("R3", "unknown clear before", 32'(err_unknown), 0);
    issue(3'd6, 2'd0, '0, '0, '0, 1'b0);
    check("R3", "unknown code flag", 32'(err_unknown), 1);
    issue(3'd0, 2'd0, 13'h0A0, '0, '0, 1'b0);
    check("R4", "reserved mode bits flag", 32'(err_mode), 1);
    lat_b = 2;
    rd_expect(2, 5, ref_mem[ref_idx(2, brow[2], 5)], "R4");

    // R12: sticky, then cleared by reset
    repeat (5) issue(3'd7, 2'd0, '0, '0, '0, 1'b0);
    check("R12", "all flags held", 32'(errs()), 32'h3F);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1", "flags cleared by reset", 32'(errs()), 0);
    check("R1", "dq_rd cleared by reset", 32'(dq_rd), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule